// File: doc/BRIEF.md
# Cascaded Weighted-Fair / Round-Robin Priority Cell Scheduler

This block decides which logical queue may send a cell in each output slot. Every queue raises a flag while it holds at least one cell. A per-queue class code places it in one of three first-stage arbiters. The real-time class uses a round-robin arbiter. The guaranteed-rate class uses a weighted deficit round-robin arbiter, and each of its queues has its own weight. The best-effort class uses a second round-robin arbiter. A strict priority selector then picks among the three first-stage winners. Real-time traffic is served first, guaranteed-rate traffic second, and best-effort traffic takes whatever is left.

A programmable pacer sets the output rate. Slots are spaced `slot_interval + 1` clock cycles apart, and each slot produces at most one grant. The grant carries a 13-bit queue index and the class it was served at. Queue 0 is the real-time bypass: it is always treated as real-time, whatever its class code says. The number of queues actually built is a parameter.

Top module: `prio_cascade_sched`

## Requirements
- R1: `slot_strobe` is high for one cycle in every `slot_interval + 1` cycles. With an interval of 0 it is high in every cycle after the first clock edge out of reset.
- R2: `grant_valid` is high only in a cycle where `slot_strobe` is high, so each slot carries at most one grant.
- R3: In a slot decided while any pending queue is mapped to real-time (class code 0), the grant goes to a real-time queue and `grant_level` reads 0. The class codes are 0 = real-time, 1 = guaranteed-rate, 2 = best-effort and 3 = disabled. Class code `q` sits at bits `[2q+1:2q]` of `queue_class`.
- R4: A guaranteed-rate queue (`grant_level` 1) is granted only in a slot where no real-time queue is pending.
- R5: A best-effort queue (`grant_level` 2) is granted only in a slot where no real-time or guaranteed-rate queue is pending.
- R6: Within the real-time and best-effort classes, grants rotate in ascending queue order. The search starts just past the last queue granted in that class, wraps at `NUM_Q`, and skips queues that are not pending. After reset the search starts at queue 0.
- R7: Continuously pending guaranteed-rate queues each receive as many back-to-back grants as their weight (`queue_weight[q*WEIGHT_W +: WEIGHT_W]`), in ascending queue order. A weight of 0 counts as 1.
- R8: Queue 0 is always served as real-time, even when its class code is 1, 2 or 3.
- R9: A queue other than queue 0 whose class code is 3 is never granted.
- R10: A slot with no eligible pending queue leaves `grant_valid` low while `slot_strobe` still pulses.
- R11: An arbiter's rotation point moves only in slots that it wins at the priority stage. A best-effort rotation is therefore unchanged by slots that real-time traffic takes.
- R12: After reset, `grant_valid` and `slot_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_pending | input | NUM_Q | One flag per queue, high while the queue holds a cell |
| queue_class | input | 2*NUM_Q | Two-bit class code per queue |
| queue_weight | input | WEIGHT_W*NUM_Q | Guaranteed-rate weight per queue |
| slot_interval | input | INTERVAL_W | Slot spacing minus one, in cycles |
| slot_strobe | output | 1 | High for one cycle per slot |
| grant_valid | output | 1 | A queue is granted in this slot |
| grant_queue | output | QIDX_W | Index of the granted queue |
| grant_level | output | 2 | Class the grant was served at (0, 1 or 2) |

## Verification
The bench builds situations in which a lower class holds pending cells while a higher class also has work. A selector that does not respect strict order would let best-effort or guaranteed-rate cells out early. Rotation is checked across a wrap and across skipped, non-pending queues, where a wrong pointer update repeats a queue or starves one.

Two further cases target state kept between slots. The weighted arbiter must hand out exactly as many back-to-back grants as each weight, with weight 0 treated as 1; a credit off by one shifts the pattern. The best-effort pointer must hold still while real-time traffic takes slots; advancing it in those slots would skip a queue. Queue 0 with a disabled class code, a disabled queue alone, and an empty slot check that the bypass override holds and that no grant appears when nothing is eligible.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      CLS_RT  = 2'd0,
      CLS_GR  = 2'd1,
      CLS_BE  = 2'd2,
      CLS_OFF = 2'd3
   } sched_class_e;

   localparam int unsigned NUM_CLASSES = 3;

endpackage

// File: rtl/sched_pacer.sv
module sched_pacer #(
   parameter int unsigned INTERVAL_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [INTERVAL_W-1:0] slot_interval,
   output logic                  tick
);

   logic [INTERVAL_W-1:0] cnt_q;

   if (INTERVAL_W < 1) begin : g_bad_width
      $error("sched_pacer: INTERVAL_W must be at least 1");
   end

   assign tick = rst_n && (cnt_q >= slot_interval);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slot_interval != '0) |=> (!tick || $changed(slot_interval))); // R1

endmodule

// File: rtl/sched_rr_arb.sv
module sched_rr_arb #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          advance,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);

   logic [IW-1:0] ptr_q;

   if (N < 2) begin : g_bad_n
      $error("sched_rr_arb: N must be at least 2");
   end

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int off = int'(N) - 1; off >= 0; off--) begin
         int s;
         s = int'(ptr_q) + off;
         if (s >= int'(N)) s = s - int'(N);
         if (req[s]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IW'(s);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (advance && gnt_valid) begin
         if (int'(gnt_idx) == int'(N) - 1) ptr_q <= '0;
         else                              ptr_q <= gnt_idx + 1'b1;
      end
   end

endmodule

// File: rtl/sched_wdrr_arb.sv
module sched_wdrr_arb #(
   parameter int unsigned N        = 8,
   parameter int unsigned WEIGHT_W = 4,
   parameter int unsigned IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          req,
   input  logic [N*WEIGHT_W-1:0] weight,
   input  logic                  advance,
   output logic                  gnt_valid,
   output logic [IW-1:0]         gnt_idx
);

   logic [IW-1:0]       ptr_q;
   logic [WEIGHT_W-1:0] credit_q [N];
   logic [WEIGHT_W-1:0] w_eff    [N];
   logic [WEIGHT_W-1:0] avail;
   logic [WEIGHT_W-1:0] left;

   if (N < 2 || WEIGHT_W < 1) begin : g_bad_cfg
      $error("sched_wdrr_arb: N must be >= 2 and WEIGHT_W >= 1");
   end

   for (genvar q = 0; q < N; q++) begin : g_weff
      assign w_eff[q] = (weight[q*WEIGHT_W +: WEIGHT_W] == '0)
                        ? WEIGHT_W'(1) : weight[q*WEIGHT_W +: WEIGHT_W];
   end

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int off = int'(N) - 1; off >= 0; off--) begin
         int s;
         s = int'(ptr_q) + off;
         if (s >= int'(N)) s = s - int'(N);
         if (req[s]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IW'(s);
         end
      end
   end

   // A queue resumes with its residual credit only if the pointer still rests on it.
   assign avail = (gnt_idx == ptr_q && credit_q[gnt_idx] != '0)
                  ? credit_q[gnt_idx] : w_eff[gnt_idx];
   assign left  = avail - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int q = 0; q < int'(N); q++) credit_q[q] <= '0;
      end else begin
         for (int q = 0; q < int'(N); q++) begin
            if (!req[q]) credit_q[q] <= '0;
         end
         if (advance && gnt_valid) begin
            credit_q[gnt_idx] <= left;
            if (left == '0) begin
               if (int'(gnt_idx) == int'(N) - 1) ptr_q <= '0;
               else                              ptr_q <= gnt_idx + 1'b1;
            end else begin
               ptr_q <= gnt_idx;
            end
         end
      end
   end

   AST_WFQ_CREDIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && gnt_valid && avail > WEIGHT_W'(1)) |=> (ptr_q == $past(gnt_idx))); // R7

endmodule

// File: rtl/prio_cascade_sched.sv
module prio_cascade_sched
   import sched_pkg::*;
#(
   parameter int unsigned NUM_Q      = 8,
   parameter int unsigned QIDX_W     = 13,
   parameter int unsigned WEIGHT_W   = 4,
   parameter int unsigned INTERVAL_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_Q-1:0]          cell_pending,
   input  logic [2*NUM_Q-1:0]        queue_class,
   input  logic [WEIGHT_W*NUM_Q-1:0] queue_weight,
   input  logic [INTERVAL_W-1:0]     slot_interval,
   output logic                      slot_strobe,
   output logic                      grant_valid,
   output logic [QIDX_W-1:0]         grant_queue,
   output logic [1:0]                grant_level
);

   localparam int unsigned IW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

   if (NUM_Q < 2 || NUM_Q > (1 << QIDX_W) || QIDX_W < IW) begin : g_bad_cfg
      $error("prio_cascade_sched: NUM_Q must lie in [2, 2**QIDX_W]");
   end

   logic [NUM_Q-1:0] req_rt, req_gr, req_be;
   logic             tick;
   logic             v_rt, v_gr, v_be;
   logic [IW-1:0]    i_rt, i_gr, i_be;
   logic             win_rt, win_gr, win_be;
   logic             any_win;
   logic [IW-1:0]    win_idx;
   logic [1:0]       win_lvl;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_cls
      sched_class_e cls;
      if (q == 0) begin : g_bypass
         assign cls = CLS_RT;
      end else begin : g_mapped
         assign cls = sched_class_e'(queue_class[2*q +: 2]);
      end
      assign req_rt[q] = cell_pending[q] && (cls == CLS_RT);
      assign req_gr[q] = cell_pending[q] && (cls == CLS_GR);
      assign req_be[q] = cell_pending[q] && (cls == CLS_BE);
   end

   sched_pacer #(.INTERVAL_W(INTERVAL_W)) u_pacer (
      .clk(clk), .rst_n(rst_n), .slot_interval(slot_interval), .tick(tick)
   );

   sched_rr_arb #(.N(NUM_Q), .IW(IW)) u_rt_arb (
      .clk(clk), .rst_n(rst_n), .req(req_rt), .advance(tick && win_rt),
      .gnt_valid(v_rt), .gnt_idx(i_rt)
   );

   sched_wdrr_arb #(.N(NUM_Q), .WEIGHT_W(WEIGHT_W), .IW(IW)) u_gr_arb (
      .clk(clk), .rst_n(rst_n), .req(req_gr), .weight(queue_weight),
      .advance(tick && win_gr), .gnt_valid(v_gr), .gnt_idx(i_gr)
   );

   sched_rr_arb #(.N(NUM_Q), .IW(IW)) u_be_arb (
      .clk(clk), .rst_n(rst_n), .req(req_be), .advance(tick && win_be),
      .gnt_valid(v_be), .gnt_idx(i_be)
   );

   // Strict priority stage over the three first-stage winners.
   assign win_rt  = v_rt;
   assign win_gr  = !v_rt && v_gr;
   assign win_be  = !v_rt && !v_gr && v_be;
   assign any_win = win_rt || win_gr || win_be;

   always_comb begin
      win_idx = i_be;
      win_lvl = 2'(CLS_BE);
      if (win_rt) begin
         win_idx = i_rt;
         win_lvl = 2'(CLS_RT);
      end else if (win_gr) begin
         win_idx = i_gr;
         win_lvl = 2'(CLS_GR);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_strobe <= 1'b0;
         grant_valid <= 1'b0;
         grant_queue <= '0;
         grant_level <= '0;
      end else begin
         slot_strobe <= tick;
         grant_valid <= tick && any_win;
         if (tick && any_win) begin
            grant_queue <= QIDX_W'(win_idx);
            grant_level <= win_lvl;
         end
      end
   end

   AST_GRANT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> slot_strobe); // R2

   AST_RT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (|req_rt)) |=> (grant_valid && grant_level == 2'd0)); // R3

   AST_GR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(|req_rt) && (|req_gr)) |=> (grant_valid && grant_level == 2'd1)); // R4

   AST_BE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(|req_rt) && !(|req_gr) && (|req_be))
         |=> (grant_valid && grant_level == 2'd2)); // R5

   AST_BYPASS_RT: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && grant_queue == '0) |-> (grant_level == 2'd0)); // R8

   AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(|req_rt) && !(|req_gr) && !(|req_be)) |=> !grant_valid); // R10

endmodule

// File: tb/prio_cascade_sched_bench.sv
`timescale 1ns/1ps
module prio_cascade_sched_bench;

   localparam int NQ = 8;
   localparam int QW = 13;
   localparam int WW = 4;
   localparam int IVW = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NQ-1:0]   cell_pending;
   logic [2*NQ-1:0] queue_class;
   logic [WW*NQ-1:0] queue_weight;
   logic [IVW-1:0]  slot_interval;
   logic            slot_strobe;
   logic            grant_valid;
   logic [QW-1:0]   grant_queue;
   logic [1:0]      grant_level;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   prio_cascade_sched #(.NUM_Q(NQ), .QIDX_W(QW), .WEIGHT_W(WW), .INTERVAL_W(IVW))
   u_prio_cascade_sched (
      .clk(clk), .rst_n(rst_n), .cell_pending(cell_pending),
      .queue_class(queue_class), .queue_weight(queue_weight),
      .slot_interval(slot_interval), .slot_strobe(slot_strobe),
      .grant_valid(grant_valid), .grant_queue(grant_queue),
      .grant_level(grant_level)
   );

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic set_cls(input int q, input logic [1:0] c);
      queue_class[2*q +: 2] = c;
   endtask

   task automatic set_w(input int q, input int w);
      queue_weight[q*WW +: WW] = WW'(w);
   endtask

   // Reset with all queues disabled and idle; release lands on a falling edge.
   task automatic reset_dut(input int interval);
      @(negedge clk);
      rst_n         = 1'b0;
      cell_pending  = '0;
      queue_class   = '1;
      queue_weight  = '0;
      for (int q = 0; q < NQ; q++) set_w(q, 1);
      slot_interval = IVW'(interval);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic expect_grant(input int q, input int lvl, input string r);
      @(negedge clk);
      chk(grant_valid && slot_strobe && int'(grant_queue) == q && int'(grant_level) == lvl,
          r, grant_valid ? int'(grant_queue) : -1, q);
   endtask

   task automatic t_reset;
      reset_dut(0);
      cell_pending = 8'hFF;
      rst_n = 1'b0;
      @(negedge clk);
      chk(!grant_valid && !slot_strobe, "R12", int'(grant_valid), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_pacing;
      int gap;
      int bad;
      reset_dut(3);
      cell_pending[1] = 1'b1;
      set_cls(1, 2'd0);
      while (!slot_strobe) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         gap = 0;
         do begin
            @(negedge clk);
            gap++;
         end while (!slot_strobe && gap < 50);
         chk(gap == 4, "R1", gap, 4);
      end
      bad = 0;
      for (int c = 0; c < 24; c++) begin
         @(negedge clk);
         if (grant_valid && !slot_strobe) bad++;
         if (slot_strobe && !grant_valid) bad++;
      end
      chk(bad == 0, "R2", bad, 0);
   endtask

   task automatic t_priority;
      reset_dut(0);
      set_cls(1, 2'd0); set_cls(2, 2'd1); set_cls(5, 2'd2);
      cell_pending = 8'b0010_0110;
      expect_grant(1, 0, "R3");
      expect_grant(1, 0, "R3");
      cell_pending[1] = 1'b0;
      expect_grant(2, 1, "R4");
      cell_pending[2] = 1'b0;
      expect_grant(5, 2, "R5");
   endtask

   task automatic t_rr_rotate;
      reset_dut(0);
      set_cls(0, 2'd3); set_cls(1, 2'd0); set_cls(3, 2'd0);
      cell_pending = 8'b0000_1011;
      expect_grant(0, 0, "R8");
      expect_grant(1, 0, "R6");
      expect_grant(3, 0, "R6");
      expect_grant(0, 0, "R6 wrap");
      expect_grant(1, 0, "R6");
   endtask

   task automatic t_wdrr;
      int seq_a[8] = '{2, 2, 2, 3, 2, 2, 2, 3};
      int seq_b[6] = '{4, 5, 5, 4, 5, 5};
      reset_dut(0);
      set_cls(2, 2'd1); set_cls(3, 2'd1);
      set_w(2, 3); set_w(3, 1);
      cell_pending = 8'b0000_1100;
      foreach (seq_a[i]) expect_grant(seq_a[i], 1, "R7");
      reset_dut(0);
      set_cls(4, 2'd1); set_cls(5, 2'd1);
      set_w(4, 0); set_w(5, 2);
      cell_pending = 8'b0011_0000;
      foreach (seq_b[i]) expect_grant(seq_b[i], 1, "R7 zero weight");
   endtask

   task automatic t_hold_ptr;
      reset_dut(0);
      set_cls(1, 2'd0); set_cls(5, 2'd2); set_cls(6, 2'd2);
      cell_pending = 8'b0110_0000;
      expect_grant(5, 2, "R11");
      cell_pending[1] = 1'b1;
      expect_grant(1, 0, "R11");
      expect_grant(1, 0, "R11");
      cell_pending[1] = 1'b0;
      expect_grant(6, 2, "R11");
      expect_grant(5, 2, "R11");
   endtask

   task automatic t_disabled_idle;
      reset_dut(0);
      set_cls(7, 2'd3);
      cell_pending = 8'b1000_0000;
      repeat (3) begin
         @(negedge clk);
         chk(!grant_valid && slot_strobe, "R9", int'(grant_valid), 0);
      end
      cell_pending = '0;
      @(negedge clk);
      chk(!grant_valid && slot_strobe, "R10", int'(grant_valid), 0);
      set_cls(7, 2'd2);
      cell_pending[7] = 1'b1;
      expect_grant(7, 2, "R9 re-enabled");
   endtask

   initial begin
      rst_n = 1'b0;
      cell_pending = '0;
      queue_class = '1;
      queue_weight = '0;
      slot_interval = '0;
      t_reset();
      t_pacing();
      t_priority();
      t_rr_rotate();
      t_wdrr();
      t_hold_ptr();
      t_disabled_idle();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule